// File: doc/BRIEF.md
# Nonvolatile Store Program/Erase Sequencer

This controller runs the complete pin sequence that erases or programs a 20-bit nonvolatile store. A host asks for one of three operations by pulsing a start input: erase, write, or erase followed by write. The sequencer owns three control lines: a program-mode line, a bank-select line and a shadow-load line. It sets them to the pattern the operation needs and waits a setup interval. It then raises one of two programming-pulse enables for a fixed width and waits a hold interval. A write also ends with the shadow-load line held low for a short interval. After that the lines go back to their idle levels.

The two enables drive an external pulse generator. The negative-polarity pulse erases the store and the positive-polarity pulse writes it. A write can only clear bits, so it ANDs new data with the stored contents. For that reason the combined command runs an erase and then a write with no host involvement in between. The shadow-load line is not toggled between the two phases, so the data waiting in the shadow register is not overwritten by the store contents. Every interval is a parameter counted in clock cycles. At a 50 MHz clock, the nominal 25 ms pulse is a count of 1,250,000.

Top module: `nvm_pulse_seq`

## Requirements
- R1: During reset and while idle, prog_mode is 0, bank_sel is 1, shadow_load is 1, both pulse enables are 0, and busy and done are 0.
- R2: An erase holds prog_mode, bank_sel and shadow_load at 1 for SETUP_CYC cycles, then raises pulse_neg_en for PULSE_CYC cycles, then holds the same pins for HOLD_CYC cycles with the enable low.
- R3: A write holds prog_mode=1, bank_sel=0 and shadow_load=1 for SETUP_CYC cycles, then raises pulse_pos_en for PULSE_CYC cycles, then holds those pins for HOLD_CYC cycles.
- R4: After its hold interval, a write drives shadow_load to 0 for LOADLOW_CYC cycles (prog_mode=1, bank_sel=0) before the pins return to idle. shadow_load falls at no other time.
- R5: The combined command runs the full erase sequence and then the full write sequence back to back. shadow_load stays 1 across the boundary between them, and done is raised only once, after the write.
- R6: The two pulse enables are never high together, and both are low whenever busy is 0.
- R7: busy rises in the cycle after an accepted start and stays high through the last cycle of the sequence.
- R8: done is high for exactly one cycle, in the first idle cycle after an operation, and never while busy.
- R9: Start inputs that are sampled while busy is 1 (including the cycle in which the last phase ends) have no effect on the sequence.
- R10: When several starts are sampled together at idle, the combined command wins over erase, and erase wins over write.
- R11: A start sampled in the cycle where done is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_erase | input | 1 | Request an erase (sampled at idle) |
| start_write | input | 1 | Request a write (sampled at idle) |
| start_both | input | 1 | Request erase followed by write |
| prog_mode | output | 1 | Program-mode control line |
| bank_sel | output | 1 | Bank-select control line (high for erase, low for write) |
| shadow_load | output | 1 | Shadow-register load line (low ends a write) |
| pulse_pos_en | output | 1 | Enable for the positive (write) programming pulse |
| pulse_neg_en | output | 1 | Enable for the negative (erase) programming pulse |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The sequencer is driven with a lone erase, a lone write and the combined command, and every cycle of the pin pattern is compared. This separates the two pin patterns, the two pulse polarities and the write-only shadow-load-low tail. Runs with all three starts held on every other cycle of a sequence show whether requests made while busy leak into the sequence. Simultaneous starts at idle exercise the priority order. Starts issued in the done cycle show whether a new operation is accepted without a dead cycle between two operations.

// File: rtl/nvm_seq_pkg.sv
// Shared types for the program/erase sequencer.
// Assumes: used only by the nvm_pulse_seq hierarchy.
package nvm_seq_pkg;

    // Phase of the running sequence
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_PULSE  = 3'd2,
        PH_HOLD   = 3'd3,
        PH_FINISH = 3'd4
    } phase_e;

    // Kind of the phase in progress
    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

endpackage

// File: rtl/nvm_seq_timer.sv
// Loadable down-counter that measures one phase interval.
// Assumes: the loaded value is the interval length minus one; expired is
// high while the count is zero, and the counter holds at zero.
module nvm_seq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Count down to zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Interval end flag
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/nvm_seq_fsm.sv
// Phase controller: accepts start requests at idle, steps through
// setup / pulse / hold (/ finish for writes), chains erase into write for
// the combined command, and produces busy and the done strobe.
// Assumes: every interval parameter is at least 1.
module nvm_seq_fsm
    import nvm_seq_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 50,
    parameter int unsigned PULSE_CYC   = 1250000,
    parameter int unsigned HOLD_CYC    = 50,
    parameter int unsigned LOADLOW_CYC = 50
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_erase,
    input  logic   start_write,
    input  logic   start_both,
    output phase_e phase_nxt,
    output op_e    op_nxt,
    output logic   busy,
    output logic   done
);

    localparam int unsigned MAX_AB  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int unsigned MAX_CD  = (HOLD_CYC > LOADLOW_CYC) ? HOLD_CYC : LOADLOW_CYC;
    localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CW-1:0] LD_SETUP   = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_PULSE   = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD    = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_LOADLOW = CW'(LOADLOW_CYC - 1);

    phase_e        phase_q;
    op_e           op_q;
    logic          chain_q, chain_d;
    logic          done_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;

    nvm_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Next-phase selection and timer reload
    always_comb begin
        phase_nxt = phase_q;
        op_nxt    = op_q;
        chain_d   = chain_q;
        done_d    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = LD_SETUP;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_both || start_erase || start_write) begin
                    phase_nxt = PH_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                    chain_d   = start_both;
                    op_nxt    = (start_both || start_erase) ? OP_ERASE : OP_WRITE;
                end
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    phase_nxt = PH_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_PULSE;
                end
            end
            PH_PULSE: begin
                if (tmr_expired) begin
                    phase_nxt = PH_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_HOLD;
                end
            end
            PH_HOLD: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (op_q == OP_WRITE) begin
                        phase_nxt = PH_FINISH;
                        tmr_val   = LD_LOADLOW;
                    end else if (chain_q) begin
                        phase_nxt = PH_SETUP;
                        op_nxt    = OP_WRITE;
                        chain_d   = 1'b0;
                        tmr_val   = LD_SETUP;
                    end else begin
                        phase_nxt = PH_IDLE;
                        done_d    = 1'b1;
                    end
                end
            end
            PH_FINISH: begin
                if (tmr_expired) begin
                    phase_nxt = PH_IDLE;
                    done_d    = 1'b1;
                end
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Phase, kind and completion registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_ERASE;
            chain_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_nxt;
            op_q    <= op_nxt;
            chain_q <= chain_d;
            done    <= done_d;
        end
    end

    // Busy whenever a phase other than idle is active
    always_comb busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/nvm_seq_drive.sv
// Registered pin decoder: turns the next phase and kind into the control
// line levels and the two pulse enables, so every pin leaves a flop.
// Assumes: phase/op inputs are the controller's next-state values.
module nvm_seq_drive
    import nvm_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_nxt,
    input  op_e    op_nxt,
    output logic   prog_mode,
    output logic   bank_sel,
    output logic   shadow_load,
    output logic   pulse_pos_en,
    output logic   pulse_neg_en
);

    logic mode_d, sel_d, load_d, pos_d, neg_d;

    // Pin pattern for each phase and kind
    always_comb begin
        mode_d = 1'b0;
        sel_d  = 1'b1;
        load_d = 1'b1;
        pos_d  = 1'b0;
        neg_d  = 1'b0;
        if (phase_nxt != PH_IDLE) begin
            mode_d = 1'b1;
            sel_d  = (op_nxt == OP_ERASE);
            load_d = (phase_nxt != PH_FINISH);
            if (phase_nxt == PH_PULSE) begin
                pos_d = (op_nxt == OP_WRITE);
                neg_d = (op_nxt == OP_ERASE);
            end
        end
    end

    // Output flops, idle levels in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_mode    <= 1'b0;
            bank_sel     <= 1'b1;
            shadow_load  <= 1'b1;
            pulse_pos_en <= 1'b0;
            pulse_neg_en <= 1'b0;
        end else begin
            prog_mode    <= mode_d;
            bank_sel     <= sel_d;
            shadow_load  <= load_d;
            pulse_pos_en <= pos_d;
            pulse_neg_en <= neg_d;
        end
    end

endmodule

// File: rtl/nvm_pulse_seq.sv
// Top of the program/erase sequencer: phase controller plus pin decoder.
// Assumes: start inputs are synchronous to clk; intervals are >= 1 cycle.
module nvm_pulse_seq
    import nvm_seq_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 50,
    parameter int unsigned PULSE_CYC   = 1250000,
    parameter int unsigned HOLD_CYC    = 50,
    parameter int unsigned LOADLOW_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_erase,
    input  logic start_write,
    input  logic start_both,
    output logic prog_mode,
    output logic bank_sel,
    output logic shadow_load,
    output logic pulse_pos_en,
    output logic pulse_neg_en,
    output logic busy,
    output logic done
);

    phase_e phase_nxt;
    op_e    op_nxt;

    nvm_seq_fsm #(
        .SETUP_CYC   (SETUP_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .LOADLOW_CYC (LOADLOW_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_erase (start_erase),
        .start_write (start_write),
        .start_both  (start_both),
        .phase_nxt   (phase_nxt),
        .op_nxt      (op_nxt),
        .busy        (busy),
        .done        (done)
    );

    nvm_seq_drive u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_nxt    (phase_nxt),
        .op_nxt       (op_nxt),
        .prog_mode    (prog_mode),
        .bank_sel     (bank_sel),
        .shadow_load  (shadow_load),
        .pulse_pos_en (pulse_pos_en),
        .pulse_neg_en (pulse_neg_en)
    );

endmodule

// File: rtl/nvm_pulse_seq_chk.sv
// Property checker for nvm_pulse_seq, attached by bind below.
// Assumes: observes top-level ports only.
module nvm_pulse_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_erase,
    input logic start_write,
    input logic start_both,
    input logic prog_mode,
    input logic bank_sel,
    input logic shadow_load,
    input logic pulse_pos_en,
    input logic pulse_neg_en,
    input logic busy,
    input logic done
);

    // R6
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_pos_en && pulse_neg_en));

    // R6
    enables_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pulse_pos_en && !pulse_neg_en));

    // R2
    erase_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_neg_en |-> (prog_mode && bank_sel && shadow_load));

    // R3
    write_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_pos_en |-> (prog_mode && !bank_sel && shadow_load));

    // R4
    load_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shadow_load) |-> (busy && prog_mode && !bank_sel));

    // R7
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_erase || start_write || start_both));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    combined_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_both) |=> (busy && bank_sel && prog_mode));

    // R10
    erase_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_both && start_erase && start_write) |=> (busy && bank_sel));

endmodule

bind nvm_pulse_seq nvm_pulse_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_erase  (start_erase),
    .start_write  (start_write),
    .start_both   (start_both),
    .prog_mode    (prog_mode),
    .bank_sel     (bank_sel),
    .shadow_load  (shadow_load),
    .pulse_pos_en (pulse_pos_en),
    .pulse_neg_en (pulse_neg_en),
    .busy         (busy),
    .done         (done)
);

// File: tb/sim_nvm_pulse_seq.sv
// Scoreboard bench: the driver pushes one expected pin vector per cycle,
// the monitor pops and compares it after each rising edge.
module sim_nvm_pulse_seq;

    localparam int SU = 3;
    localparam int PW = 5;
    localparam int HD = 2;
    localparam int LL = 2;

    // Expected vector order: busy, done, mode, sel, load, pos, neg
    localparam logic [6:0] X_IDLE = 7'b0_0_0_1_1_0_0;
    localparam logic [6:0] X_DONE = 7'b0_1_0_1_1_0_0;
    localparam logic [6:0] X_ESH  = 7'b1_0_1_1_1_0_0;
    localparam logic [6:0] X_EP   = 7'b1_0_1_1_1_0_1;
    localparam logic [6:0] X_WSH  = 7'b1_0_1_0_1_0_0;
    localparam logic [6:0] X_WP   = 7'b1_0_1_0_1_1_0;
    localparam logic [6:0] X_WF   = 7'b1_0_1_0_0_0_0;

    typedef struct {
        logic [6:0] exp;
        string      req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_erase = 1'b0;
    logic start_write = 1'b0;
    logic start_both = 1'b0;
    logic prog_mode, bank_sel, shadow_load, pulse_pos_en, pulse_neg_en, busy, done;

    item_t sbq[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    nvm_pulse_seq #(
        .SETUP_CYC   (SU),
        .PULSE_CYC   (PW),
        .HOLD_CYC    (HD),
        .LOADLOW_CYC (LL)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_erase  (start_erase),
        .start_write  (start_write),
        .start_both   (start_both),
        .prog_mode    (prog_mode),
        .bank_sel     (bank_sel),
        .shadow_load  (shadow_load),
        .pulse_pos_en (pulse_pos_en),
        .pulse_neg_en (pulse_neg_en),
        .busy         (busy),
        .done         (done)
    );

    // One cycle: drive {both, erase, write} and expect vector after next edge
    task automatic cyc(input logic [2:0] st, input logic [6:0] exp, input string req);
        item_t it;
        @(negedge clk);
        {start_both, start_erase, start_write} = st;
        it.exp = exp;
        it.req = req;
        sbq.push_back(it);
    endtask

    // Erase phase cycles (R2 shape); first cycle carries the start
    task automatic erase_body(input logic [2:0] st0, input bit noise, input string req);
        for (int i = 0; i < SU + PW + HD; i++) begin
            logic [2:0] st;
            st = (i == 0) ? st0 : ((noise && i[0]) ? 3'b111 : 3'b000);
            cyc(st, (i >= SU && i < SU + PW) ? X_EP : X_ESH, req);
        end
    endtask

    // Write phase cycles (R3 shape plus R4 tail)
    task automatic write_body(input logic [2:0] st0, input bit noise, input string req);
        for (int i = 0; i < SU + PW + HD + LL; i++) begin
            logic [2:0] st;
            logic [6:0] x;
            st = (i == 0) ? st0 : ((noise && i[0]) ? 3'b111 : 3'b000);
            if (i >= SU + PW + HD)     x = X_WF;
            else if (i >= SU && i < SU + PW) x = X_WP;
            else                       x = X_WSH;
            cyc(st, x, (i >= SU + PW + HD) ? "R4" : req);
        end
    endtask

    // Full operation selected by priority, then the done cycle (R8)
    task automatic run_op(input logic [2:0] st, input bit noise, input string req);
        if (st[2]) begin
            erase_body(st, noise, req);
            write_body(noise ? 3'b111 : 3'b000, noise, req);
        end else if (st[1]) begin
            erase_body(st, noise, req);
        end else begin
            write_body(st, noise, req);
        end
        cyc(noise ? 3'b111 : 3'b000, X_DONE, "R8");
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                logic [6:0] act;
                it  = sbq.pop_front();
                act = {busy, done, prog_mode, bank_sel, shadow_load, pulse_pos_en, pulse_neg_en};
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b (busy,done,mode,sel,load,pos,neg)",
                             it.req, act, it.exp);
                end
            end
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        cyc(3'b000, X_IDLE, "R1");        // R1 reset levels
        cyc(3'b111, X_IDLE, "R1");        // starts ignored while in reset
        @(negedge clk);
        rst_n = 1'b1;
        {start_both, start_erase, start_write} = 3'b000;
        cyc(3'b000, X_IDLE, "R1");
        cyc(3'b000, X_IDLE, "R1");
        run_op(3'b010, 1'b0, "R2");       // lone erase
        cyc(3'b000, X_IDLE, "R1");
        run_op(3'b001, 1'b0, "R3");       // lone write
        cyc(3'b000, X_IDLE, "R1");
        run_op(3'b100, 1'b0, "R5");       // combined, R7 busy in each vector
        cyc(3'b000, X_IDLE, "R1");
        run_op(3'b001, 1'b1, "R9");       // write with starts while busy
        cyc(3'b000, X_IDLE, "R1");
        run_op(3'b010, 1'b1, "R9");       // erase with starts while busy
        cyc(3'b000, X_IDLE, "R1");
        run_op(3'b011, 1'b0, "R10");      // erase beats write
        cyc(3'b000, X_IDLE, "R1");
        run_op(3'b111, 1'b0, "R10");      // combined beats both
        run_op(3'b001, 1'b0, "R11");      // accepted right after done
        run_op(3'b010, 1'b0, "R11");
        cyc(3'b000, X_IDLE, "R1");        // R6 enables low at idle
        cyc(3'b000, X_IDLE, "R1");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule